// File: doc/BRIEF.md
# PHY Test-Port Trim Sequencer

This block loads a short list of trim settings into a PHY that is reachable only through a narrow test port. The port has one command word going out and one byte of readback coming in. Each list entry names a PHY register, a bit field inside it (upper and lower bit position) and a value. For every entry the engine reads the register, merges the new field into the byte it read, and writes the byte back. The write uses a single isolated write strobe. A dummy read follows the write. Every command is held on the port for a fixed number of readback cycles before the next one is driven.

A start pulse launches a pass over the first `entry_count_i` entries, in table order. `busy_o` is high for the whole pass and `done_o` pulses for one clock when the pass ends. When the legacy input is high, the pass makes no port traffic at all and completes at once. The table arrives as flat parallel vectors and must stay stable while `busy_o` is high.

Top module: `tport_seq`

## Requirements
- R1: The command word carries the data byte in bits 13:6, the register address in bits 5:1 and the write strobe in bit 0. While the engine is idle, or is selecting an entry, the word is zero.
- R2: Once a command is driven, it stays unchanged for SAMPLES clock cycles (default 2) before the next command replaces it.
- R3: Each valid entry starts with a read command (data 1, the entry's address, strobe 0). At the end of this command the engine captures the readback byte.
- R4: The write phase drives three commands with the same address and data: strobe 0, then strobe 1, then strobe 0. This gives exactly one strobe pulse per valid entry.
- R5: The written byte takes bits msb..lsb from the low bits of the entry value. All its other bits come from the captured readback byte, so only the addressed field changes.
- R6: After the write phase comes a dummy read command (data 1, same address, strobe 0) whose readback is discarded. A pass lasts count + 5*SAMPLES*valid cycles, and `done_o` is high in the cycle after that. Here count is the number of entries and valid is the number of valid entries.
- R7: Entries are applied strictly in table order, up to 7 of them. When two entries write the same register, the later one leaves its field on top.
- R8: With legacy mode high at start, no command is driven and `done_o` is high in the first cycle after start.
- R9: `busy_o` is high from the cycle after an accepted start until the pass ends. A start while busy is ignored. `done_o` is a single-cycle pulse, never high together with `busy_o`.
- R10: An entry count of zero completes with `done_o` in the first cycle after start, and drives no command.
- R11: An entry is invalid when msb is below lsb or msb is above 7. An invalid entry is skipped without port traffic in one cycle and sets `err_o`. An accepted start clears `err_o`.
- R12: A synchronous active-high reset returns the engine to idle. After reset the command word is zero and `busy_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a pass |
| legacy_i | input | 1 | Skip all programming when high |
| entry_count_i | input | 3 | Number of table entries to apply |
| tbl_addr_i | input | 35 | Register address per entry, 5 bits each, entry 0 lowest |
| tbl_msb_i | input | 28 | Field upper bit per entry, 4 bits each |
| tbl_lsb_i | input | 28 | Field lower bit per entry, 4 bits each |
| tbl_val_i | input | 56 | Field value per entry, 8 bits each |
| testo_i | input | 8 | Readback byte from the PHY test port |
| testi_o | output | 14 | Command word to the PHY test port |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| err_o | output | 1 | At least one entry of the last pass was skipped |

## Verification
The bench uses the default parameters: 7 entries, SAMPLES of 2, an 8-bit data byte and 4-bit position fields. The 4-bit positions let the bench pose msb and lsb values of 8 and 9. Those values reach the out-of-range skip, so a single-entry sweep covers every msb/lsb pair from 0 to 9: every field width and offset plus every invalid shape. Multi-entry tables with repeated addresses, a mix of invalid entries and every count from 0 to 7 run against a modelled 32-register PHY. These runs bring in ordering, read-merge behaviour and the cycle count of each pass. Legacy mode, a start while busy and a reset in the middle of a pass complete the coverage.

// File: rtl/tport_pkg.sv
package tport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_RD,
    ST_WR0,
    ST_WR1,
    ST_WR2,
    ST_DUM
  } seq_st_e;

  // true when bit b lies inside the field [hi:lo]
  function automatic logic in_field(int b, int hi, int lo);
    return (b >= lo) && (b <= hi);
  endfunction

endpackage

// File: rtl/tport_pacer.sv
module tport_pacer #(
  parameter int SAMPLES = 2,
  localparam int CW = $clog2(SAMPLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == CW'(SAMPLES - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (last_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tport_entry_pick.sv
module tport_entry_pick #(
  parameter int MAX_ENTRIES = 7,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int POS_W = 4,
  parameter int CNT_W = 3
) (
  input  logic [MAX_ENTRIES*ADDR_W-1:0] tbl_addr_i,
  input  logic [MAX_ENTRIES*POS_W-1:0]  tbl_msb_i,
  input  logic [MAX_ENTRIES*POS_W-1:0]  tbl_lsb_i,
  input  logic [MAX_ENTRIES*DATA_W-1:0] tbl_val_i,
  input  logic [CNT_W-1:0]              idx_i,
  output logic [ADDR_W-1:0]             addr_o,
  output logic [POS_W-1:0]              msb_o,
  output logic [POS_W-1:0]              lsb_o,
  output logic [DATA_W-1:0]             val_o,
  output logic                          ok_o
);
  logic [ADDR_W-1:0] addr_a [MAX_ENTRIES];
  logic [POS_W-1:0]  msb_a  [MAX_ENTRIES];
  logic [POS_W-1:0]  lsb_a  [MAX_ENTRIES];
  logic [DATA_W-1:0] val_a  [MAX_ENTRIES];

  for (genvar g = 0; g < MAX_ENTRIES; g++) begin : g_unpack
    assign addr_a[g] = tbl_addr_i[g*ADDR_W +: ADDR_W];
    assign msb_a[g]  = tbl_msb_i[g*POS_W +: POS_W];
    assign lsb_a[g]  = tbl_lsb_i[g*POS_W +: POS_W];
    assign val_a[g]  = tbl_val_i[g*DATA_W +: DATA_W];
  end

  always_comb begin
    addr_o = '0;
    msb_o  = '0;
    lsb_o  = '0;
    val_o  = '0;
    for (int k = 0; k < MAX_ENTRIES; k++) begin
      if (idx_i == CNT_W'(k)) begin
        addr_o = addr_a[k];
        msb_o  = msb_a[k];
        lsb_o  = lsb_a[k];
        val_o  = val_a[k];
      end
    end
  end

  // R11: field must sit inside the byte with msb >= lsb
  assign ok_o = (msb_o <= POS_W'(DATA_W - 1)) && (lsb_o <= msb_o);
endmodule

// File: rtl/tport_merge.sv
module tport_merge
  import tport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int POS_W = 4
) (
  input  logic [DATA_W-1:0] prev_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [POS_W-1:0]  msb_i,
  input  logic [POS_W-1:0]  lsb_i,
  output logic [DATA_W-1:0] byte_o
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    mask = '0;
    for (int b = 0; b < DATA_W; b++) mask[b] = in_field(b, int'(msb_i), int'(lsb_i));
  end

  assign shifted = val_i << lsb_i;
  // R5: keep bits outside the field from the captured byte
  assign byte_o = (prev_i & ~mask) | (shifted & mask);
endmodule

// File: rtl/tport_cmd.sv
module tport_cmd
  import tport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  localparam int CMD_W = DATA_W + ADDR_W + 1
) (
  input  seq_st_e            st_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wr_byte_i,
  output logic [CMD_W-1:0]   cmd_o
);
  // R1: {data, address, strobe}
  always_comb begin
    case (st_i)
      ST_RD, ST_DUM:  cmd_o = {DATA_W'(1), addr_i, 1'b0};
      ST_WR0, ST_WR2: cmd_o = {wr_byte_i, addr_i, 1'b0};
      ST_WR1:         cmd_o = {wr_byte_i, addr_i, 1'b1};
      default:        cmd_o = '0;
    endcase
  end
endmodule

// File: rtl/tport_seq.sv
module tport_seq
  import tport_pkg::*;
#(
  parameter int MAX_ENTRIES = 7,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int SAMPLES = 2,
  localparam int POS_W = $clog2(DATA_W) + 1,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int CMD_W = DATA_W + ADDR_W + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic                          legacy_i,
  input  logic [CNT_W-1:0]              entry_count_i,
  input  logic [MAX_ENTRIES*ADDR_W-1:0] tbl_addr_i,
  input  logic [MAX_ENTRIES*POS_W-1:0]  tbl_msb_i,
  input  logic [MAX_ENTRIES*POS_W-1:0]  tbl_lsb_i,
  input  logic [MAX_ENTRIES*DATA_W-1:0] tbl_val_i,
  input  logic [DATA_W-1:0]             testo_i,
  output logic [CMD_W-1:0]              testi_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          err_o
);
  seq_st_e           st_q;
  logic [CNT_W-1:0]  idx_q;
  logic [DATA_W-1:0] prev_q;
  logic              done_q, err_q;

  logic [ADDR_W-1:0] ent_addr;
  logic [POS_W-1:0]  ent_msb, ent_lsb;
  logic [DATA_W-1:0] ent_val, wr_byte;
  logic              ent_ok, ph_last, in_cmd;
  logic [CNT_W-1:0]  cnt_eff;
  logic              last_idx, entry_begin, pass_quick;

  assign cnt_eff    = (entry_count_i > CNT_W'(MAX_ENTRIES)) ? CNT_W'(MAX_ENTRIES) : entry_count_i;
  assign last_idx   = (idx_q == (cnt_eff - 1'b1));
  assign in_cmd     = (st_q != ST_IDLE) && (st_q != ST_SEL);
  assign entry_begin = (st_q == ST_SEL) && ent_ok;
  assign pass_quick = legacy_i || (cnt_eff == '0);

  tport_entry_pick #(
    .MAX_ENTRIES(MAX_ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .POS_W(POS_W), .CNT_W(CNT_W)
  ) u_pick (
    .tbl_addr_i(tbl_addr_i), .tbl_msb_i(tbl_msb_i), .tbl_lsb_i(tbl_lsb_i),
    .tbl_val_i(tbl_val_i), .idx_i(idx_q), .addr_o(ent_addr), .msb_o(ent_msb),
    .lsb_o(ent_lsb), .val_o(ent_val), .ok_o(ent_ok)
  );

  tport_merge #(.DATA_W(DATA_W), .POS_W(POS_W)) u_merge (
    .prev_i(prev_q), .val_i(ent_val), .msb_i(ent_msb), .lsb_i(ent_lsb), .byte_o(wr_byte)
  );

  tport_pacer #(.SAMPLES(SAMPLES)) u_pacer (
    .clk(clk), .rst(rst), .run_i(in_cmd), .last_o(ph_last)
  );

  tport_cmd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cmd (
    .st_i(st_q), .addr_i(ent_addr), .wr_byte_i(wr_byte), .cmd_o(testi_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      prev_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          err_q <= 1'b0;
          idx_q <= '0;
          if (pass_quick) done_q <= 1'b1;
          else            st_q   <= ST_SEL;
        end
        ST_SEL: begin
          if (ent_ok) st_q <= ST_RD;
          else begin
            err_q <= 1'b1;
            if (last_idx) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else idx_q <= idx_q + 1'b1;
          end
        end
        ST_RD: if (ph_last) begin
          prev_q <= testo_i;
          st_q   <= ST_WR0;
        end
        ST_WR0: if (ph_last) st_q <= ST_WR1;
        ST_WR1: if (ph_last) st_q <= ST_WR2;
        ST_WR2: if (ph_last) st_q <= ST_DUM;
        ST_DUM: if (ph_last) begin
          if (last_idx) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_SEL;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  // ---------------- assertions ----------------
  localparam int RW = $clog2(SAMPLES + 2) + 1;
  logic [CMD_W-1:0] seen_cmd_q;
  logic [RW-1:0]    hold_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_cmd_q <= '0;
      hold_run_q <= '0;
    end else if (testi_o != seen_cmd_q) begin
      seen_cmd_q <= testi_o;
      hold_run_q <= RW'(1);
    end else if (hold_run_q != '1) begin
      hold_run_q <= hold_run_q + 1'b1;
    end
  end

  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (testi_o != seen_cmd_q && seen_cmd_q != '0) |-> (hold_run_q >= RW'(SAMPLES)));

  // R4
  strobe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(testi_o[0]) |-> ($past(testi_o) == {testi_o[CMD_W-1:1], 1'b0}));

  // R4
  strobe_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(testi_o[0]) |-> (testi_o[CMD_W-1:1] == $past(testi_o[CMD_W-1:1])));

  // R3
  read_first_chk: assert property (@(posedge clk) disable iff (rst)
    entry_begin |=> (testi_o == {DATA_W'(1), $past(ent_addr), 1'b0}));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R8
  legacy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && legacy_i && !busy_o) |=> (done_o && !busy_o && testi_o == '0));

  // R1
  idle_word_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (testi_o == '0));
endmodule

// File: tb/test_tport_seq.sv
module test_tport_seq;
  localparam int NE = 7;
  localparam int SMP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic leg = 1'b0;
  logic [2:0] cnt = '0;
  logic [NE*5-1:0] t_addr_f;
  logic [NE*4-1:0] t_msb_f, t_lsb_f;
  logic [NE*8-1:0] t_val_f;
  logic [7:0]  testo;
  logic [13:0] testi;
  logic busy, done, err;

  logic [4:0] t_reg [NE];
  logic [3:0] t_msb [NE];
  logic [3:0] t_lsb [NE];
  logic [7:0] t_val [NE];

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NE; k++) begin
      t_addr_f[k*5 +: 5] = t_reg[k];
      t_msb_f[k*4 +: 4]  = t_msb[k];
      t_lsb_f[k*4 +: 4]  = t_lsb[k];
      t_val_f[k*8 +: 8]  = t_val[k];
    end
  end

  tport_seq i_tport_seq (
    .clk(clk), .rst(rst), .start_i(start), .legacy_i(leg), .entry_count_i(cnt),
    .tbl_addr_i(t_addr_f), .tbl_msb_i(t_msb_f), .tbl_lsb_i(t_lsb_f), .tbl_val_i(t_val_f),
    .testo_i(testo), .testi_o(testi), .busy_o(busy), .done_o(done), .err_o(err)
  );

  // PHY model: 32 byte registers behind the test port
  logic [7:0]  phy_mem [32];
  logic        load_req = 1'b0;
  int          seed_v = 0;
  int          strobes;
  logic        we_prev;
  logic        cap_arm;
  logic [13:0] first_cmd;

  function automatic logic [7:0] pre_val(int i, int s);
    return 8'((i * 29 + s * 71 + 5) & 255);
  endfunction

  assign testo = phy_mem[testi[5:1]];

  always @(posedge clk) begin
    if (load_req) begin
      for (int i = 0; i < 32; i++) phy_mem[i] <= pre_val(i, seed_v);
      strobes   <= 0;
      we_prev   <= 1'b0;
      cap_arm   <= 1'b1;
      first_cmd <= '0;
    end else begin
      if (testi[0]) phy_mem[testi[5:1]] <= testi[13:6];
      if (testi[0] && !we_prev) strobes <= strobes + 1;
      we_prev <= testi[0];
      if (cap_arm && testi != '0) begin
        first_cmd <= testi;
        cap_arm   <= 1'b0;
      end
    end
  end

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit ent_valid(int k);
    return (t_msb[k] <= 7) && (t_lsb[k] <= t_msb[k]);
  endfunction

  task automatic do_run(input int n, input bit lg, input int s, input bit poke);
    logic [7:0] em [32];
    int valid, cyc, mism, exp_cyc, exp_first, extra_done;
    bit any_bad, seen_first;
    // expected PHY contents and port traffic from the requirements
    for (int i = 0; i < 32; i++) em[i] = pre_val(i, s);
    valid = 0; any_bad = 0; seen_first = 0; exp_first = 0;
    if (!lg) begin
      for (int k = 0; k < n; k++) begin
        if (ent_valid(k)) begin
          valid++;
          if (!seen_first) begin
            seen_first = 1;
            exp_first = (1 << 6) | (int'(t_reg[k]) << 1);
          end
          for (int b = 0; b < 8; b++)
            if (b >= int'(t_lsb[k]) && b <= int'(t_msb[k]))
              em[t_reg[k]][b] = t_val[k][b - int'(t_lsb[k])];
        end else any_bad = 1;
      end
    end
    exp_cyc = lg ? 1 : (n + 5 * SMP * valid + 1);

    seed_v = s;
    @(negedge clk); load_req = 1'b1;
    @(negedge clk); load_req = 1'b0;
    cnt = 3'(n); leg = lg;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
      start = poke && (cyc == 3);
    end
    start = 1'b0;
    // R6 R8 R10: pass length
    check(cyc == exp_cyc, "R6", "done cycle", cyc, exp_cyc);
    check(!busy, "R9", "busy with done", int'(busy), 0);
    // R11: skip flag
    check(err == any_bad, "R11", "err flag", int'(err), int'(any_bad));
    // R4: one strobe per valid entry
    check(strobes == valid, "R4", "strobe count", strobes, valid);
    // R3 R8 R10: first command word (0 when no traffic)
    check(int'(first_cmd) == exp_first, "R3", "first command", int'(first_cmd), exp_first);
    mism = 0;
    for (int i = 0; i < 32; i++) if (phy_mem[i] != em[i]) mism++;
    // R5 R7: merged field contents in table order
    check(mism == 0, "R5/R7", "mismatched PHY registers", mism, 0);
    if (poke) begin
      extra_done = 0;
      for (int j = 0; j < 15; j++) begin
        @(negedge clk);
        if (done || busy) extra_done++;
      end
      // R9: start while busy ignored
      check(extra_done == 0, "R9", "activity after ignored start", extra_done, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NE; k++) begin
      t_reg[k] = '0; t_msb[k] = '0; t_lsb[k] = '0; t_val[k] = '0;
    end
    repeat (3) @(negedge clk);
    // R12: reset state
    check(testi == '0, "R12", "testi in reset", int'(testi), 0);
    check(!busy && !done && !err, "R12", "flags in reset", int'({busy, done, err}), 0);
    rst = 1'b0;
    @(negedge clk);

    // R10: zero count
    do_run(0, 1'b0, 1, 1'b0);
    // R8: legacy with a full table
    for (int k = 0; k < NE; k++) begin
      t_reg[k] = 5'(k + 2); t_msb[k] = 4'd7; t_lsb[k] = 4'd0; t_val[k] = 8'(k * 17);
    end
    do_run(7, 1'b1, 2, 1'b0);

    // R5 R11: single entry, every msb/lsb pair 0..9
    for (int m = 0; m < 10; m++) begin
      for (int l = 0; l < 10; l++) begin
        t_reg[0] = 5'((m * 3 + l) % 32);
        t_msb[0] = 4'(m);
        t_lsb[0] = 4'(l);
        t_val[0] = 8'((m * 13 + l * 5 + 1) & 255);
        do_run(1, 1'b0, m + l, 1'b0);
      end
    end

    // R7: multi-entry tables with repeated addresses and mixed validity
    for (int s = 0; s < 6; s++) begin
      for (int k = 0; k < NE; k++) begin
        t_reg[k] = 5'((k * 5 + s) % 8);
        t_msb[k] = 4'((k + s) % 8);
        t_lsb[k] = 4'((k * 3 + s) % 8);
        t_val[k] = 8'((k * 59 + s * 23 + 7) & 255);
      end
      for (int n = 1; n <= NE; n++) do_run(n, 1'b0, s * 8 + n, 1'b0);
    end

    // R9: start pulse while busy
    for (int k = 0; k < NE; k++) begin
      t_reg[k] = 5'(k); t_msb[k] = 4'(k); t_lsb[k] = 4'd0; t_val[k] = 8'hA5;
    end
    do_run(3, 1'b0, 40, 1'b1);

    // R12: reset in the middle of a pass
    cnt = 3'd3; leg = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    check(busy, "R9", "busy during pass", int'(busy), 1);
    rst = 1'b1;
    @(negedge clk);
    check(testi == '0 && !busy && !done, "R12", "state after mid-pass reset",
          int'({testi, busy, done}), 0);
    rst = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule